// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical frame number. It walks a two-level translation tree held in memory. A 32-bit virtual address with 4 KB pages gives a 20-bit page number. The upper ten bits of that number select an entry in the top table. That entry names the frame of a second-level table. The lower ten bits then select the leaf entry, and the leaf entry holds the target frame. The 12-bit page offset is not part of the walk; the caller joins it to the returned frame unchanged.

The caller supplies the frame of the top table on a root input. It then hands over one page number at a time, together with an access-type flag. The walker issues 32-bit descriptor reads on a memory port that has a request handshake and a separate response strobe, so memory latency may vary. A walk ends with a one-cycle result that carries either the frame or a fault code. The code shows whether the walk stopped at the top table or at the leaf table.

Because the walk stops at a missing top entry, sparse address spaces need no second-level table for regions they do not use. A typical consumer is the refill path of a translation cache.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk uses the address `(root_frame << 12) + 4 * req_vpn[19:10]`.
- R3: If bit 0 of the top descriptor is 0, the walk ends with `rsp_fault` = 1 and `rsp_frame` = 0. No second memory read is issued.
- R4: If bit 0 of the top descriptor is 1, the second read uses the address `(top_desc[31:12] << 12) + 4 * req_vpn[9:0]`.
- R5: If bit 0 of the leaf descriptor is 0, the walk ends with `rsp_fault` = 2 and `rsp_frame` = 0.
- R6: If bit 0 of the leaf descriptor is 1, the walk ends with `rsp_fault` = 0 and `rsp_frame` = `leaf_desc[31:12]`. Descriptor bits 11:1 have no effect on any result, and fault code 3 never appears.
- R7: A request is accepted only while `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance through the result cycle. `req_valid` asserted while busy starts no walk. `rsp_valid` is a single-cycle pulse.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. At most one read is outstanding, and no new read is issued before `mem_rsp_valid` returns.
- R9: `root_frame`, `req_vpn` and `req_write` are sampled only at acceptance. Changing them during a walk has no effect on that walk.
- R10: `rsp_write` returns the access-type flag captured with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the top table |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | 20 | Virtual page number to translate |
| req_write | input | 1 | Access type, 1 = write |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_frame | output | 20 | Translated frame, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 top entry absent, 2 leaf entry absent |
| rsp_write | output | 1 | Access type of the finished walk |

## Verification
The assertions assume that memory pulses `mem_rsp_valid` only while one read is outstanding. They also assume that memory answers every accepted read exactly once. The bench memory model meets both assumptions: it records a read only when it has nothing pending, and it returns each read once after a random delay of zero to three cycles. Its ready signal is random, which exercises held requests. Descriptor contents come from a fixed function of the address, with garbage in bits 11:1, so present and absent entries occur at both levels.

// File: rtl/pwalk_pkg.sv
`timescale 1ns/1ps
package pwalk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_TOP  = 2'd1,
        FLT_LEAF = 2'd2
    } pw_fault_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_TOP_REQ   = 3'd1,
        ST_TOP_WAIT  = 3'd2,
        ST_LEAF_REQ  = 3'd3,
        ST_LEAF_WAIT = 3'd4,
        ST_DONE      = 3'd5
    } pw_state_e;

endpackage

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
// Forms a descriptor byte address from a table frame and an entry index.
module pw_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10,
    parameter int DESC_BYTES_LOG2 = 2,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic [FRAME_W-1:0] table_frame,
    input  logic [IDX_W-1:0]   entry_idx,
    output logic [ADDR_W-1:0]  desc_addr
);
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] entry_ofs;

    always_comb begin
        base_addr = ADDR_W'(table_frame) << OFF_W;
        entry_ofs = ADDR_W'(entry_idx) << DESC_BYTES_LOG2;
        desc_addr = base_addr + entry_ofs;
    end
endmodule

// File: rtl/pw_desc_dec.sv
`timescale 1ns/1ps
// Splits a descriptor into its presence flag and frame field.
module pw_desc_dec #(
    parameter int DESC_W  = 32,
    parameter int FRAME_W = 20
) (
    input  logic [DESC_W-1:0]  desc,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    logic unused_desc_bits;

    assign present          = desc[0];
    assign frame            = desc[DESC_W-1 -: FRAME_W];
    assign unused_desc_bits = ^desc[DESC_W-FRAME_W-1:1];
endmodule

// File: rtl/pw_walk_ctrl.sv
`timescale 1ns/1ps
// Walk sequencer: holds the captured request and the current table frame.
module pw_walk_ctrl
    import pwalk_pkg::*;
#(
    parameter int FRAME_W = 20,
    parameter int VPN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic               req_write,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               desc_present,
    input  logic [FRAME_W-1:0] desc_frame,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic               leaf_phase,
    output logic [FRAME_W-1:0] base_frame,
    output logic [VPN_W-1:0]   vpn,
    output logic               rsp_valid,
    output logic [FRAME_W-1:0] rsp_frame,
    output pw_fault_e          rsp_fault,
    output logic               rsp_write
);
    typedef struct packed {
        pw_state_e          state;
        logic [VPN_W-1:0]   vpn;
        logic               write;
        logic [FRAME_W-1:0] base;
        logic [FRAME_W-1:0] frame;
        pw_fault_e          fault;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.vpn   = req_vpn;
                    walk_d.write = req_write;
                    walk_d.base  = root_frame;
                    walk_d.frame = '0;
                    walk_d.fault = FLT_NONE;
                    walk_d.state = ST_TOP_REQ;
                end
            end
            ST_TOP_REQ: begin
                if (mem_req_ready) walk_d.state = ST_TOP_WAIT;
            end
            ST_TOP_WAIT: begin
                if (mem_rsp_valid) begin
                    if (desc_present) begin
                        walk_d.base  = desc_frame;
                        walk_d.state = ST_LEAF_REQ;
                    end else begin
                        walk_d.fault = FLT_TOP;
                        walk_d.frame = '0;
                        walk_d.state = ST_DONE;
                    end
                end
            end
            ST_LEAF_REQ: begin
                if (mem_req_ready) walk_d.state = ST_LEAF_WAIT;
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    if (desc_present) begin
                        walk_d.frame = desc_frame;
                        walk_d.fault = FLT_NONE;
                    end else begin
                        walk_d.frame = '0;
                        walk_d.fault = FLT_LEAF;
                    end
                    walk_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                walk_d.state = ST_IDLE;
            end
            default: begin
                walk_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q.state <= ST_IDLE;
            walk_q.vpn   <= '0;
            walk_q.write <= 1'b0;
            walk_q.base  <= '0;
            walk_q.frame <= '0;
            walk_q.fault <= FLT_NONE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.state == ST_IDLE);
    assign mem_req_valid = (walk_q.state == ST_TOP_REQ) || (walk_q.state == ST_LEAF_REQ);
    assign leaf_phase    = (walk_q.state == ST_LEAF_REQ) || (walk_q.state == ST_LEAF_WAIT);
    assign base_frame    = walk_q.base;
    assign vpn           = walk_q.vpn;
    assign rsp_valid     = (walk_q.state == ST_DONE);
    assign rsp_frame     = walk_q.frame;
    assign rsp_fault     = walk_q.fault;
    assign rsp_write     = walk_q.write;
endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
module pgwalk_top
    import pwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int DESC_W = 32,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int VPN_W   = 2 * IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic               req_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [DESC_W-1:0]  mem_rsp_data,
    output logic               rsp_valid,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [1:0]         rsp_fault,
    output logic               rsp_write
);
    logic               desc_present;
    logic [FRAME_W-1:0] desc_frame;
    logic               leaf_phase;
    logic [FRAME_W-1:0] base_frame;
    logic [VPN_W-1:0]   vpn_q;
    logic [IDX_W-1:0]   entry_idx;
    pw_fault_e          fault_code;

    pw_desc_dec #(.DESC_W(DESC_W), .FRAME_W(FRAME_W)) i_dec (
        .desc    (mem_rsp_data),
        .present (desc_present),
        .frame   (desc_frame)
    );

    pw_walk_ctrl #(.FRAME_W(FRAME_W), .VPN_W(VPN_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vpn       (req_vpn),
        .req_write     (req_write),
        .root_frame    (root_frame),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .desc_present  (desc_present),
        .desc_frame    (desc_frame),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .leaf_phase    (leaf_phase),
        .base_frame    (base_frame),
        .vpn           (vpn_q),
        .rsp_valid     (rsp_valid),
        .rsp_frame     (rsp_frame),
        .rsp_fault     (fault_code),
        .rsp_write     (rsp_write)
    );

    // Upper index field selects the top entry, lower field the leaf entry.
    assign entry_idx = leaf_phase ? vpn_q[IDX_W-1:0] : vpn_q[VPN_W-1:IDX_W];
    assign rsp_fault = fault_code;

    pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                  .DESC_BYTES_LOG2($clog2(DESC_W / 8))) i_agen (
        .table_frame (base_frame),
        .entry_idx   (entry_idx),
        .desc_addr   (mem_req_addr)
    );
endmodule

// File: rtl/pw_walk_chk.sv
`timescale 1ns/1ps
module pw_walk_chk #(
    parameter int ADDR_W  = 32,
    parameter int FRAME_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               mem_rsp_valid,
    input logic               rsp_valid,
    input logic [FRAME_W-1:0] rsp_frame,
    input logic [1:0]         rsp_fault
);
    logic [1:0] reads_q;
    logic       outstanding_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q       <= '0;
            outstanding_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) reads_q <= '0;
            else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
            if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
            else if (mem_rsp_valid) outstanding_q <= 1'b0;
        end
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R8
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !mem_req_valid);
    // R3
    top_fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 2'd1 |-> reads_q == 2'd1 && rsp_frame == '0);
    // R5
    leaf_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd1 |-> reads_q == 2'd2);
    // R6
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'd3);
endmodule

bind pgwalk_top pw_walk_chk #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) i_walk_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_frame     (rsp_frame),
    .rsp_fault     (rsp_fault)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] root_frame;
    logic        req_valid;
    logic        req_ready;
    logic [19:0] req_vpn;
    logic        req_write;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [19:0] rsp_frame;
    logic [1:0]  rsp_fault;
    logic        rsp_write;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    logic [31:0] addr_log [2];

    always #10 clk = ~clk;

    pgwalk_top i_pgwalk_top (.*);

    // Descriptor contents as a function of address; bits 11:1 carry garbage.
    function automatic logic [31:0] mem_data(input logic [31:0] a);
        logic [19:0] f;
        logic [9:0]  w;
        f = a[31:12];
        w = a[11:2];
        if (f[19:8] == 12'h00A)
            return {10'h100, w ^ {2'b00, f[7:0]}, 11'h5AA, (w % 3) != 0};
        else if (f[19:10] == 10'h100)
            return {{f[9:0], w} ^ 20'h5A5A5, 11'h2D3 ^ {1'b0, w}, ((f[9:0] ^ w) & 10'd3) != 0};
        else
            return 32'h0;
    endfunction

    function automatic logic [31:0] desc_addr(input logic [19:0] fr, input logic [9:0] idx);
        return {fr, 12'h000} + {20'h0, idx, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: random ready, one read at a time, random latency.
    initial begin
        bit         pend;
        int         lat;
        logic [31:0] paddr;
        pend = 0; lat = 0; paddr = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_data(paddr);
                    pend = 0;
                end else lat--;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (!pend && !mem_rsp_valid && mem_req_valid === 1'b1 && mem_req_ready) begin
                pend  = 1;
                paddr = mem_req_addr;
                lat   = $urandom % 4;
                if (rd_cnt < 2) addr_log[rd_cnt] = mem_req_addr;
                rd_cnt++;
            end
        end
    end

    task automatic walk(input logic [19:0] vpn, input logic wr, input logic [19:0] root, input bit poke);
        logic [31:0] a0, a1, d0, d1;
        logic [19:0] e_frame;
        logic [1:0]  e_fault;
        int          e_reads;
        int          guard;
        bit          busy_bad;
        a0 = desc_addr(root, vpn[19:10]);
        d0 = mem_data(a0);
        a1 = desc_addr(d0[31:12], vpn[9:0]);
        d1 = mem_data(a1);
        if (!d0[0])      begin e_fault = 2'd1; e_frame = '0; e_reads = 1; end
        else if (!d1[0]) begin e_fault = 2'd2; e_frame = '0; e_reads = 2; end
        else             begin e_fault = 2'd0; e_frame = d1[31:12]; e_reads = 2; end

        @(negedge clk);
        chk(req_ready === 1'b1, "R7 idle before request", {31'h0, req_ready}, 32'h1);
        root_frame = root; req_vpn = vpn; req_write = wr; req_valid = 1'b1;
        rd_cnt = 0;
        @(negedge clk);
        // R9: disturb captured inputs; R7: optionally keep requesting while busy
        req_valid  = poke;
        req_vpn    = ~vpn;
        req_write  = ~wr;
        root_frame = root ^ 20'h00055;
        guard = 0; busy_bad = 0;
        while (rsp_valid !== 1'b1 && guard < 400) begin
            if (req_ready !== 1'b0) busy_bad = 1;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        chk(!busy_bad && guard < 400, "R7 busy while walking", {31'h0, busy_bad}, 32'h0);
        chk(rsp_fault === e_fault, (e_fault == 1) ? "R3 fault code" : (e_fault == 2) ? "R5 fault code" : "R6 fault code",
            {30'h0, rsp_fault}, {30'h0, e_fault});
        chk(rsp_frame === e_frame, (e_fault == 0) ? "R6 frame" : "R3/R5 zero frame", {12'h0, rsp_frame}, {12'h0, e_frame});
        chk(rsp_write === wr, "R10 access type", {31'h0, rsp_write}, {31'h0, wr});
        chk(rd_cnt == e_reads, (e_reads == 1) ? "R3 single read" : "R4 two reads", rd_cnt, e_reads);
        chk(addr_log[0] === a0, "R2 top address (R9 root captured)", addr_log[0], a0);
        if (e_reads == 2)
            chk(addr_log[1] === a1, "R4 leaf address", addr_log[1], a1);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R7 pulse then idle",
            {30'h0, rsp_valid, req_ready}, 32'h1);
        chk(rd_cnt == e_reads, "R7 busy request ignored", rd_cnt, e_reads);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R7 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; req_write = 1'b0; root_frame = 20'h00A00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid === 1'b0, "R1 no result after reset", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid === 1'b0, "R1 no read after reset", {31'h0, mem_req_valid}, 32'h0);

        // directed corners
        walk(20'h00000, 1'b0, 20'h00A00, 0);   // R3 top entry 0 absent
        walk(20'h00401, 1'b1, 20'h00A00, 1);   // R5 leaf absent
        walk(20'h00402, 1'b0, 20'h00A00, 0);   // R6 success
        walk(20'hFFFFF, 1'b1, 20'h00AFF, 1);   // highest indices
        walk(20'h00C00, 1'b0, 20'h00A3C, 0);   // top idx 3 absent

        for (int i = 0; i < 150; i++)
            walk(20'($urandom), 1'($urandom), {12'h00A, 8'($urandom)}, 1'($urandom));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule